// File: doc/BRIEF.md
# DMA FIFO Request Handshake

This block sits between a host bus and an external DMA controller and holds two 16-bit FIFOs: a receive FIFO that the internal side fills and the bus drains, and a transmit FIFO that the bus fills and the internal side drains. For each direction it drives an active-high request to the DMA controller and takes an active-low acknowledge back. While an acknowledge is low, a bus strobe in the matching direction reaches the FIFO whatever the chip select and word address say. Without the acknowledge, the FIFO is reached only through its own address while the block is selected.

A request is withdrawn within the very cycle in which the access that moves the final word begins. On the receive side that is the read of the last stored word. On the transmit side it is the write into the last free slot. The DMA controller therefore sees the request fall while that access is still running, and it neither reads past empty nor writes past full. Each direction has a small handshake state machine whose state is derived from the FIFO's next occupancy. In HS_IDLE nothing can be moved. In HS_ARMED two or more words can be moved. In HS_LAST exactly one can. Every clock, the state machine moves to whichever of these matches the next occupancy: IDLE to ARMED or LAST on a fill, LAST to IDLE on the final access, ARMED to LAST when one word or slot is left, and so on. In HS_LAST the request follows the inverse of the access strobe.

The internal side pushes received words and pops transmit words over plain valid/ready ports. A bus read of an empty receive FIFO, or a bus write to a full transmit FIFO, is dropped and raises a sticky error flag that a clear input resets.

Top module: `dma_fifo_hs`

## Requirements
- R1: After reset both FIFOs are empty, rx_req is 0, tx_req is 1, rx_err and tx_err are 0, rx_in_ready is 1 and tx_out_valid is 0.
- R2: rx_req is 0 whenever the receive FIFO is empty, and 1 whenever it holds two or more words.
- R3: When the receive FIFO holds exactly one word, rx_req is 1 while no receive pop is being made, and 0 in the same cycle as a bus read that pops that word.
- R4: With rx_ack_n low, bus_rd pops the receive FIFO for any bus_cs and bus_addr. With rx_ack_n high, it pops only when bus_cs is 1 and bus_addr equals RX_ADDR (default 0).
- R5: tx_req is 0 whenever the transmit FIFO is full, and 1 whenever two or more slots are free.
- R6: When exactly one transmit slot is free, tx_req is 1 while no push is being made, and 0 in the same cycle as a bus write that fills that slot.
- R7: With tx_ack_n low, bus_wr pushes bus_wdata into the transmit FIFO for any bus_cs and bus_addr. With tx_ack_n high, it pushes only when bus_cs is 1 and bus_addr equals TX_ADDR (default 1).
- R8: Both FIFOs keep first-in first-out order. bus_rdata shows the receive head word (0 when empty), and tx_out_data shows the transmit head word.
- R9: rx_in_ready is the inverse of rx_full, and tx_out_valid is the inverse of tx_empty. The full and empty flags follow occupancy against DEPTH.
- R10: A bus pop of an empty receive FIFO, or a bus push into a full transmit FIFO, changes no stored word and sets rx_err or tx_err respectively, one cycle later. The flag stays set until err_clr is 1 on a clock edge. A new error in that same cycle wins over the clear.
- R11: A bus read or write that is neither acknowledged nor addressed to its FIFO leaves both FIFOs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Block select, active high |
| bus_addr | input | 6 | Word address within the block |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Receive head word, 0 when empty |
| rx_req | output | 1 | Receive DMA request, active high |
| rx_ack_n | input | 1 | Receive DMA acknowledge, active low |
| tx_req | output | 1 | Transmit DMA request, active high |
| tx_ack_n | input | 1 | Transmit DMA acknowledge, active low |
| rx_in_valid | input | 1 | Internal receive word valid |
| rx_in_ready | output | 1 | Receive FIFO can accept a word |
| rx_in_data | input | 16 | Internal receive word |
| tx_out_valid | output | 1 | Transmit word available |
| tx_out_ready | input | 1 | Internal side takes the transmit word |
| tx_out_data | output | 16 | Transmit head word |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| err_clr | input | 1 | Clears both sticky error flags |
| rx_err | output | 1 | Sticky receive underflow flag |
| tx_err | output | 1 | Sticky transmit overflow flag |

## Verification
The receive and transmit paths are each filled to every level from one word to DEPTH and then emptied through acknowledged accesses. At each access the request is sampled inside the access cycle, which separates an early drop on the final word from a drop one cycle late or one word early. Every combination of select and low address bits is applied with the acknowledge released, which separates the addressed window from the other addresses and separates the acknowledge override from ordinary decoding. Accesses past empty and past full check that the stored data are unchanged and that the error flags are sticky.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ARMED = 2'd1,
        HS_LAST  = 2'd2
    } hs_state_t;
endpackage

// File: rtl/hs_fifo.sv
module hs_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          full,
    output logic          empty,
    output logic          bad_op
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign bad_op  = (push && full) || (pop && empty);
    assign rdata   = mem[rptr];

    always_comb begin
        count_nxt = count;
        if (do_push && !do_pop) count_nxt = count + CW'(1);
        else if (do_pop && !do_push) count_nxt = count - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            count <= count_nxt;
            if (do_push) wptr <= (wptr == LASTP) ? '0 : wptr + PW'(1);
            if (do_pop)  rptr <= (rptr == LASTP) ? '0 : rptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/hs_req_fsm.sv
module hs_req_fsm
    import dma_hs_pkg::*;
#(
    parameter int CW        = 3,
    parameter int RST_AVAIL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] avail_nxt,
    input  logic          access,
    output logic          req
);
    function automatic hs_state_t classify(input logic [CW-1:0] n);
        if (n == '0) return HS_IDLE;
        if (n == CW'(1)) return HS_LAST;
        return HS_ARMED;
    endfunction

    localparam hs_state_t RST_STATE = classify(CW'(RST_AVAIL));

    hs_state_t state, state_nxt;

    assign state_nxt = classify(avail_nxt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RST_STATE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            HS_IDLE:  req = 1'b0;
            HS_ARMED: req = 1'b1;
            HS_LAST:  req = !access;
            default:  req = 1'b0;
        endcase
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_IDLE) |-> !req);
endmodule

// File: rtl/dma_fifo_hs.sv
module dma_fifo_hs #(
    parameter int              DEPTH   = 4,
    parameter int              DW      = 16,
    parameter int              AW      = 6,
    parameter logic [AW-1:0]   RX_ADDR = 6'd0,
    parameter logic [AW-1:0]   TX_ADDR = 6'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rx_req,
    input  logic          rx_ack_n,
    output logic          tx_req,
    input  logic          tx_ack_n,
    input  logic          rx_in_valid,
    output logic          rx_in_ready,
    input  logic [DW-1:0] rx_in_data,
    output logic          tx_out_valid,
    input  logic          tx_out_ready,
    output logic [DW-1:0] tx_out_data,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          tx_full,
    output logic          tx_empty,
    input  logic          err_clr,
    output logic          rx_err,
    output logic          tx_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          rx_pop_bus, tx_push_bus;
    logic [CW-1:0] rx_cnt, rx_cnt_nxt, tx_cnt, tx_cnt_nxt, tx_free_nxt;
    logic [DW-1:0] rx_head;
    logic          rx_bad, tx_bad;

    assign rx_pop_bus  = bus_rd && (!rx_ack_n || (bus_cs && bus_addr == RX_ADDR));
    assign tx_push_bus = bus_wr && (!tx_ack_n || (bus_cs && bus_addr == TX_ADDR));

    hs_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_in_valid && !rx_full), .pop(rx_pop_bus),
        .wdata(rx_in_data), .rdata(rx_head),
        .count(rx_cnt), .count_nxt(rx_cnt_nxt),
        .full(rx_full), .empty(rx_empty), .bad_op(rx_bad)
    );

    hs_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push_bus), .pop(tx_out_ready && !tx_empty),
        .wdata(bus_wdata), .rdata(tx_out_data),
        .count(tx_cnt), .count_nxt(tx_cnt_nxt),
        .full(tx_full), .empty(tx_empty), .bad_op(tx_bad)
    );

    assign tx_free_nxt = CW'(DEPTH) - tx_cnt_nxt;

    hs_req_fsm #(.CW(CW), .RST_AVAIL(0)) rx_fsm_i (
        .clk(clk), .rst_n(rst_n),
        .avail_nxt(rx_cnt_nxt), .access(rx_pop_bus), .req(rx_req)
    );

    hs_req_fsm #(.CW(CW), .RST_AVAIL(DEPTH)) tx_fsm_i (
        .clk(clk), .rst_n(rst_n),
        .avail_nxt(tx_free_nxt), .access(tx_push_bus), .req(tx_req)
    );

    assign bus_rdata    = rx_empty ? '0 : rx_head;
    assign rx_in_ready  = !rx_full;
    assign tx_out_valid = !tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_err <= 1'b0;
            tx_err <= 1'b0;
        end else begin
            if (rx_bad)       rx_err <= 1'b1;
            else if (err_clr) rx_err <= 1'b0;
            if (tx_bad)       tx_err <= 1'b1;
            else if (err_clr) tx_err <= 1'b0;
        end
    end

    assert_rx_empty_noreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !rx_req);
    assert_rx_last_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CW'(1) && rx_pop_bus) |-> !rx_req);
    assert_tx_full_noreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_req);
    assert_tx_last_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CW'(DEPTH - 1) && tx_push_bus) |-> !tx_req);
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !err_clr) |=> rx_err);
endmodule

// File: tb/dma_fifo_hs_tb.sv
module dma_fifo_hs_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        rx_req, tx_req;
    logic        rx_ack_n = 1'b1, tx_ack_n = 1'b1;
    logic        rx_in_valid = 1'b0, rx_in_ready;
    logic [15:0] rx_in_data = '0;
    logic        tx_out_valid, tx_out_ready = 1'b0;
    logic [15:0] tx_out_data;
    logic        rx_full, rx_empty, tx_full, tx_empty;
    logic        err_clr = 1'b0, rx_err, tx_err;

    int checks = 0, fails = 0;
    logic [15:0] rxq[$];
    logic [15:0] txq[$];
    logic [15:0] seed = 16'h1000;

    always #5 clk = ~clk;

    dma_fifo_hs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_req(rx_req), .rx_ack_n(rx_ack_n), .tx_req(tx_req), .tx_ack_n(tx_ack_n),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
        .err_clr(err_clr), .rx_err(rx_err), .tx_err(tx_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic rx_push();
        @(negedge clk);
        seed = seed + 16'h0111;
        rx_in_valid = 1'b1;
        rx_in_data  = seed;
        @(posedge clk); #1;
        rx_in_valid = 1'b0;
        if (rxq.size() < DEPTH) rxq.push_back(seed);
    endtask

    // bus read; pops iff acknowledged or addressed
    task automatic bus_read(input logic cs, input logic [5:0] a, input logic ackn);
        bit pops;
        @(negedge clk);
        bus_cs = cs; bus_addr = a; rx_ack_n = ackn; bus_rd = 1'b1;
        pops = !ackn || (cs && a == 6'd0);
        #2;
        chk_eq("R8 rdata head", bus_rdata, rxq.size() > 0 ? int'(rxq[0]) : 0);
        chk_eq("R2/R3 rx_req during read", rx_req,
               (rxq.size() > 1 || (rxq.size() == 1 && !pops)) ? 1 : 0);
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_cs = 1'b0; rx_ack_n = 1'b1;
        if (pops && rxq.size() > 0) void'(rxq.pop_front());
    endtask

    task automatic bus_write(input logic cs, input logic [5:0] a, input logic ackn);
        bit pushes;
        @(negedge clk);
        seed = seed + 16'h0203;
        bus_cs = cs; bus_addr = a; tx_ack_n = ackn; bus_wr = 1'b1; bus_wdata = seed;
        pushes = !ackn || (cs && a == 6'd1);
        #2;
        chk_eq("R5/R6 tx_req during write", tx_req,
               ((DEPTH - txq.size()) > 1 || ((DEPTH - txq.size()) == 1 && !pushes)) ? 1 : 0);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_cs = 1'b0; tx_ack_n = 1'b1;
        if (pushes && txq.size() < DEPTH) txq.push_back(seed);
    endtask

    task automatic tx_drain();
        while (txq.size() > 0) begin
            @(negedge clk);
            tx_out_ready = 1'b1;
            #2;
            chk_eq("R9 tx_out_valid", tx_out_valid, 1);
            chk_eq("R8 tx order", tx_out_data, txq[0]);
            @(posedge clk); #1;
            tx_out_ready = 1'b0;
            void'(txq.pop_front());
        end
        chk_eq("R9 tx_empty after drain", tx_empty, 1);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 rx_req", rx_req, 0);
        chk_eq("R1 tx_req", tx_req, 1);
        chk_eq("R1 rx_empty", rx_empty, 1);
        chk_eq("R1 tx_empty", tx_empty, 1);
        chk_eq("R1 errs", {rx_err, tx_err}, 0);
        chk_eq("R1 rx_in_ready", rx_in_ready, 1);
        chk_eq("R1 tx_out_valid", tx_out_valid, 0);

        // R2 R3 R4 R8 R9: every fill level, drained through acknowledged reads
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) rx_push();
            #2;
            chk_eq("R2 rx_req filled", rx_req, 1);
            chk_eq("R9 rx_full", rx_full, (n == DEPTH) ? 1 : 0);
            chk_eq("R9 rx_in_ready", rx_in_ready, (n == DEPTH) ? 0 : 1);
            for (int i = 0; i < n; i++) bus_read(i[0], 6'(i + 5), 1'b0);
            #2;
            chk_eq("R2 rx_req empty", rx_req, 0);
            chk_eq("R9 rx_empty", rx_empty, 1);
        end

        // R4 R11: decode sweep with acknowledge released
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 4; a++) begin
                while (rxq.size() < 2) rx_push();
                bus_read(c[0], 6'(a), 1'b1);
                #2;
                chk_eq("R4/R11 rx decode head", bus_rdata, rxq[0]);
            end
        end
        while (rxq.size() > 0) bus_read(1'b1, 6'd0, 1'b1);

        // R10 receive underflow
        bus_read(1'b0, 6'd9, 1'b0);
        chk_eq("R10 rx_err set", rx_err, 1);
        chk_eq("R10 rx still empty", rx_empty, 1);
        repeat (2) @(posedge clk); #1;
        chk_eq("R10 rx_err sticky", rx_err, 1);
        @(negedge clk); err_clr = 1'b1;
        @(posedge clk); #1; err_clr = 1'b0;
        chk_eq("R10 rx_err cleared", rx_err, 0);

        // R5 R6 R7 R8: every fill level through acknowledged writes
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) bus_write(i[0], 6'(i + 7), 1'b0);
            #2;
            chk_eq("R5 tx_req level", tx_req, (n == DEPTH) ? 0 : 1);
            chk_eq("R9 tx_full", tx_full, (n == DEPTH) ? 1 : 0);
            tx_drain();
            chk_eq("R5 tx_req empty", tx_req, 1);
        end

        // R7 R11: decode sweep with acknowledge released
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 4; a++) begin
                bus_write(c[0], 6'(a), 1'b1);
                #2;
                chk_eq("R7/R11 tx occupancy", tx_out_valid, txq.size() > 0 ? 1 : 0);
            end
        end
        tx_drain();

        // R10 transmit overflow
        for (int i = 0; i < DEPTH; i++) bus_write(1'b1, 6'd1, 1'b1);
        bus_write(1'b0, 6'd3, 1'b0);
        chk_eq("R10 tx_err set", tx_err, 1);
        chk_eq("R10 tx_err vs rx", rx_err, 0);
        tx_drain();
        chk_eq("R10 tx_err sticky", tx_err, 1);
        @(negedge clk); err_clr = 1'b1;
        @(posedge clk); #1; err_clr = 1'b0;
        chk_eq("R10 tx_err cleared", tx_err, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule